// File: doc/BRIEF.md
# Two-Wire Trim Configuration Slave

This block is a two-wire serial slave that owns one 8-bit trim register for a programmable differential line terminator. SCL and SDA are sampled from the system clock through two-flop synchronizers and a counter-based spike filter. Start and stop conditions are decoded from the filtered lines, and a protocol sequencer receives an address byte. That byte is compared against a 7-bit address strapped on input pins.

A transfer carries one address byte and exactly one data byte. In a write, the slave acknowledges the data byte and then loads it into the register. In a read, the slave shifts the register out MSB first. The upper nibble of the register drives the bias-current trim code and the lower nibble drives the impedance trim code. The register comes up at 0x7A, and a reload pulse restores that value. The pulse is asserted whenever the terminator leaves disconnect. SDA is driven only as an open-drain pull-down enable.

Top module: `trim_cfg_slave`

## Requirements
- R1: After reset the bias code is 4'b0111, the impedance code is 4'b1010 (register 0x7A), and the SDA pull-down enable is low.
- R2: A write addressed to the pin address is acknowledged on the ninth clock of both bytes. After the data acknowledge, the register holds the data byte: bits 7..4 go to the bias code and bits 3..0 go to the impedance code.
- R3: A read (address byte bit 0 = 1) is acknowledged. The slave then drives the register value MSB first, one bit per SCL high phase, and releases SDA for the master's ninth-clock answer.
- R4: An address byte whose bits 7..1 differ from the pin address gets no acknowledge. SDA stays released for the rest of that transfer, and the register does not change.
- R5: The address that responds is taken from the seven address pins as they are at the time of the transfer, so changing the pins moves the slave to the new address.
- R6: A reload pulse returns the register to 0x7A one clock later. While reload is asserted, a write completing in the same cycle is discarded.
- R7: A stop that arrives before the data byte has been acknowledged leaves the register unchanged.
- R8: A start (SDA falling while SCL is high) in the middle of a byte abandons that byte and restarts address reception, so a complete transfer that follows is handled normally.
- R9: A pulse on SCL or SDA shorter than FILT_CYC system clocks is ignored.
- R10: The SDA pull-down enable changes only while filtered SCL is low, except that it is released on a start or a stop (SDA rising while SCL is high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| addr_i | input | 7 | Strapped slave address |
| reload_i | input | 1 | Restore register default (leaving disconnect) |
| bias_code_o | output | 4 | Bias-current trim code (register bits 7..4) |
| imp_code_o | output | 4 | Impedance trim code (register bits 3..0) |

## Verification
Writes and reads are run with data values that have asymmetric nibbles (0x3C, 0xE1, 0x96), so swapped nibbles or a reversed bit order produce a visible mismatch. The address is tried against a value one bit away from the pins, and with the pins changed between transfers, which separates a strapped comparison from a fixed one. Aborted transfers of two kinds are tried: an early stop and a mid-byte repeated start. They show whether the register commits only after the data acknowledge. A write with short spikes injected on both lines shows whether the filter keeps extra bits and false starts out of the byte.

// File: rtl/trim_cfg_pkg.sv
package trim_cfg_pkg;
  localparam int unsigned CfgW  = 8;
  localparam int unsigned AddrW = 7;
  localparam logic [CfgW-1:0] CfgDefault = 8'h7A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/trim_line_filt.sv
module trim_line_filt #(
  parameter int unsigned FILT_CYC = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CntW = $clog2(FILT_CYC + 1);

  logic [1:0]      sync_q;
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (cnt_q == CntW'(FILT_CYC - 1)) begin
          line_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/trim_bus_cond.sv
module trim_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/trim_slave_fsm.sv
module trim_slave_fsm
  import trim_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [CfgW-1:0]  rd_data_i,
  output logic             wr_en_o,
  output logic [CfgW-1:0]  wr_data_o,
  output logic             sda_oe_o
);
  slv_state_e     state_q;
  logic [3:0]     bit_cnt_q;
  logic [CfgW-1:0] shift_q;
  logic           rw_q;

  wire byte_done = scl_fall_i && (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      rw_q      <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise_i) begin
              shift_q   <= {shift_q[CfgW-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              if (state_q == ST_WDATA) begin
                sda_oe_o <= 1'b1;
                state_q  <= ST_WDATA_ACK;
              end else if (shift_q[CfgW-1:1] == addr_i) begin
                sda_oe_o <= 1'b1;
                rw_q     <= shift_q[0];
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                shift_q  <= rd_data_i;
                sda_oe_o <= ~rd_data_i[CfgW-1];
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_WDATA;
              end
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              wr_en_o  <= 1'b1;
              state_q  <= ST_SKIP;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_SKIP;
            end else if (scl_fall_i) begin
              shift_q  <= {shift_q[CfgW-2:0], 1'b0};
              sda_oe_o <= ~shift_q[CfgW-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_data_o = shift_q;
endmodule

// File: rtl/trim_cfg_reg.sv
module trim_cfg_reg
  import trim_cfg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reload_i,
  input  logic            wr_en_i,
  input  logic [CfgW-1:0] wr_data_i,
  output logic [CfgW-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_o <= CfgDefault;
    else if (reload_i) cfg_o <= CfgDefault;
    else if (wr_en_i)  cfg_o <= wr_data_i;
  end
endmodule

// File: rtl/trim_cfg_slave.sv
module trim_cfg_slave
  import trim_cfg_pkg::*;
#(
  parameter int unsigned FILT_CYC = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [AddrW-1:0] addr_i,
  input  logic             reload_i,
  output logic [3:0]       bias_code_o,
  output logic [3:0]       imp_code_o
);
  localparam int unsigned NumLines = 2;

  logic [NumLines-1:0] raw_lines, flt_lines;
  logic scl_flt, sda_flt;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic wr_en;
  logic [CfgW-1:0] wr_data, cfg_q;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NumLines; g++) begin : g_filt
    trim_line_filt #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  trim_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_flt),
    .sda_i     (sda_flt),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  trim_slave_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_flt),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .addr_i    (addr_i),
    .rd_data_i (cfg_q),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  trim_cfg_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload_i),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .cfg_o    (cfg_q)
  );

  assign bias_code_o = cfg_q[7:4];
  assign imp_code_o  = cfg_q[3:0];
endmodule

// File: rtl/trim_cfg_slave_chk.sv
module trim_cfg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reload_i,
  input logic       scl_flt,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic       sda_oe_o,
  input logic [3:0] bias_code_o,
  input logic [3:0] imp_code_o
);
  p_reload_default_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> ({bias_code_o, imp_code_o} == 8'h7A));

  p_hold_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !wr_en) |=> $stable({bias_code_o, imp_code_o}));

  p_release_on_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  p_oe_moves_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!scl_flt || $past(stop_det) || $past(start_det)));
endmodule

bind trim_cfg_slave trim_cfg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reload_i   (reload_i),
  .scl_flt    (scl_flt),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .wr_en      (wr_en),
  .sda_oe_o   (sda_oe_o),
  .bias_code_o(bias_code_o),
  .imp_code_o (imp_code_o)
);

// File: tb/tb_trim_cfg_slave.sv
`timescale 1ns/1ps
module tb_trim_cfg_slave;
  localparam int HALF = 60;
  localparam int QTR  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic [6:0] addr = 7'h52;
  logic reload = 1'b0;
  logic sda_oe;
  logic [3:0] bias, imp;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  trim_cfg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_i(addr), .reload_i(reload),
    .bias_code_o(bias), .imp_code_o(imp)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; cyc(QTR);
    scl = 1'b1; cyc(HALF);
    sda_drv = 1'b0; cyc(HALF);
    scl = 1'b0; cyc(QTR);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; cyc(QTR);
    scl = 1'b1; cyc(HALF);
    sda_drv = 1'b1; cyc(HALF);
  endtask

  // one clock: drive b (1 = release), return line sampled mid high phase
  task automatic bus_bit(input bit b, input bit glitch, output bit got);
    sda_drv = b; cyc(QTR);
    scl = 1'b1; cyc(HALF/4);
    if (glitch) begin
      scl = 1'b0; cyc(5); scl = 1'b1; cyc(3);
      sda_drv = ~b; cyc(4); sda_drv = b; cyc(3);
    end else cyc(15);
    got = sda_line;
    cyc(HALF - HALF/4 - 15);
    scl = 1'b0; cyc(QTR);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack);
    bit g;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], glitch, g);
    bus_bit(1'b1, 1'b0, g);
    ack = ~g;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    bit g;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, 1'b0, g);
      v[i] = g;
    end
    bus_bit(1'b1, 1'b0, g);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit glitch,
                          output bit ack_a, output bit ack_d);
    bus_start;
    send_byte({a, 1'b0}, 1'b0, ack_a);
    send_byte(d, glitch, ack_d);
    bus_stop;
    cyc(40);
  endtask

  task automatic t_reset;
    cyc(3);
    check(bias == 4'b0111, "R1 bias", bias, 7);
    check(imp == 4'b1010, "R1 imp", imp, 10);
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_write;
    bit aa, ad;
    do_write(7'h52, 8'h3C, 1'b0, aa, ad);
    check(aa, "R2 addr ack", aa, 1);
    check(ad, "R2 data ack", ad, 1);
    check(bias == 4'h3, "R2 bias", bias, 3);
    check(imp == 4'hC, "R2 imp", imp, 12);
  endtask

  task automatic t_read;
    bit aa;
    logic [7:0] v;
    bus_start;
    send_byte({7'h52, 1'b1}, 1'b0, aa);
    recv_byte(v);
    bus_stop;
    cyc(40);
    check(aa, "R3 addr ack", aa, 1);
    check(v == 8'h3C, "R3 read data", v, 8'h3C);
    check(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
  endtask

  task automatic t_wrong_addr;
    bit aa, ad;
    do_write(7'h53, 8'h99, 1'b0, aa, ad);
    check(!aa, "R4 no addr ack", aa, 0);
    check(!ad, "R4 data not acked", ad, 0);
    check({bias, imp} == 8'h3C, "R4 reg unchanged", {bias, imp}, 8'h3C);
  endtask

  task automatic t_pins;
    bit aa, ad;
    addr = 7'h15; cyc(4);
    do_write(7'h15, 8'hE1, 1'b0, aa, ad);
    check(aa && ad, "R5 new pin address acked", {aa, ad}, 3);
    check({bias, imp} == 8'hE1, "R5 reg written", {bias, imp}, 8'hE1);
    do_write(7'h52, 8'h00, 1'b0, aa, ad);
    check(!aa, "R5 old address ignored", aa, 0);
    check({bias, imp} == 8'hE1, "R5 reg kept", {bias, imp}, 8'hE1);
  endtask

  task automatic t_reload;
    bit aa, ad;
    reload = 1'b1; cyc(1); reload = 1'b0; cyc(1);
    check({bias, imp} == 8'h7A, "R6 reload default", {bias, imp}, 8'h7A);
    reload = 1'b1;
    do_write(7'h15, 8'h5B, 1'b0, aa, ad);
    reload = 1'b0; cyc(2);
    check({bias, imp} == 8'h7A, "R6 reload beats write", {bias, imp}, 8'h7A);
  endtask

  task automatic t_stop_early;
    bit aa, g;
    bus_start;
    send_byte({7'h15, 1'b0}, 1'b0, aa);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, 1'b0, g);
    bus_stop;
    cyc(40);
    check(aa, "R7 addr ack", aa, 1);
    check({bias, imp} == 8'h7A, "R7 early stop no change", {bias, imp}, 8'h7A);
  endtask

  task automatic t_restart;
    bit aa, ad, g;
    bus_start;
    for (int i = 0; i < 3; i++) bus_bit(1'b0, 1'b0, g);
    bus_start;
    send_byte({7'h15, 1'b0}, 1'b0, aa);
    send_byte(8'h44, 1'b0, ad);
    bus_stop;
    cyc(40);
    check(aa && ad, "R8 acks after restart", {aa, ad}, 3);
    check({bias, imp} == 8'h44, "R8 reg after restart", {bias, imp}, 8'h44);
  endtask

  task automatic t_glitch;
    bit aa, ad;
    do_write(7'h15, 8'h96, 1'b1, aa, ad);
    check(aa && ad, "R9 acks with spikes", {aa, ad}, 3);
    check({bias, imp} == 8'h96, "R9 data with spikes", {bias, imp}, 8'h96);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    t_reset;
    t_write;
    t_read;
    t_wrong_addr;
    t_pins;
    t_reload;
    t_stop_early;
    t_restart;
    t_glitch;
    done = 1'b1;
    finish_sim;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim;
    end
  end
endmodule